// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a 32-bit processor core whose visible set of sixteen registers depends on the current operating mode. Indices 0 to 7 always reach the same storage. Indices 8 to 12 have a second copy that only the fast-interrupt mode sees. Indices 13 (stack pointer) and 14 (link register) have a private pair in each of the five exception modes. Index 15 is the program counter, which is the same for all modes. Each exception mode also owns one saved status word. The user and system modes share one bank and have no saved status word.

The core loads the current mode through a dedicated write port and reads the registered mode back. From the next cycle on, every access uses the bank that this registered mode selects. The block has two combinational read ports, one clocked write port, a saved-status read/write port for the current mode, and a dedicated program-counter write. It does not execute instructions and does not decide when the mode changes.

Top module: `banked_regfile`

## Requirements
- R1: After reset the registered mode is supervisor (5'b10011), the program counter is 0, and every register and saved status word reads 0.
- R2: A mode write stores `mode_wr_data` into `cur_mode` at the clock edge, and bank selection uses `cur_mode` from then on. Mode codes: user 10000, fast interrupt 10001, normal interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111.
- R3: Both read ports are combinational. A register write lands at the clock edge, so a read of the same register in the same cycle returns the old value.
- R4: Indices 0 to 7 reach one shared storage location per index in every mode.
- R5: Indices 8 to 12 reach a private copy in fast-interrupt mode. Every other mode reaches the user copy.
- R6: Indices 13 and 14 reach a private copy in each of fast interrupt, normal interrupt, supervisor, abort and undefined. User and system modes share the user copy.
- R7: A mode code outside the seven listed selects the user bank and has no saved status word.
- R8: Each exception mode has its own saved status word. In user, system or an unlisted mode the saved-status port reads 0 and a write to it changes no stored word.
- R9: Index 15 on either read port returns the program counter. A write through the register port to index 15, or through `pc_wr_en`, updates it. When both occur in one cycle, `pc_wr_data` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_en | input | 1 | Load a new mode |
| mode_wr_data | input | 5 | Mode code to load |
| cur_mode | output | 5 | Registered current mode |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| sst_wr_en | input | 1 | Saved-status write enable |
| sst_wr_data | input | 32 | Saved-status write data |
| sst_rd_data | output | 32 | Saved status of the current mode |
| pc_wr_en | input | 1 | Dedicated program-counter write |
| pc_wr_data | input | 32 | Program-counter write data |
| pc_q | output | 32 | Program counter |

## Verification
The program counter can be written by two paths in the same cycle: the general write port addressed to index 15 and the dedicated program-counter write. The bench raises both in one cycle with different data and expects the dedicated value on `pc_q` and on a read of index 15 after the edge. A second collision pairs a write with a same-cycle read of the same register. The read must still show the old value before the edge and the new value after it.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

    localparam int NSHARED = 8;   // indices 0..7, common to every mode
    localparam int NHIGH   = 5;   // indices 8..12, fast-interrupt overlay
    localparam int NBANK   = 6;   // user/system plus five exception banks
    localparam int NPAIR   = 2;   // stack pointer and link register
    localparam int NGPR    = NSHARED + 2 * NHIGH + NBANK * NPAIR;
    localparam int NSST    = NBANK - 1;
    localparam int PHYS_W  = $clog2(NGPR);
    localparam int IDX_W   = 4;
    localparam int MODE_W  = 5;
    localparam logic [IDX_W-1:0] PC_IDX = 4'd15;
    localparam logic [IDX_W-1:0] SP_IDX = 4'd13;
    localparam logic [IDX_W-1:0] HI_IDX = 4'd8;

    typedef enum logic [MODE_W-1:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_ABT = 5'b10111,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } mode_e;

    typedef enum logic [2:0] {
        B_USR = 3'd0,
        B_FIQ = 3'd1,
        B_IRQ = 3'd2,
        B_SVC = 3'd3,
        B_ABT = 3'd4,
        B_UND = 3'd5
    } bank_e;

endpackage

// File: rtl/bankrf_mode_dec.sv
module bankrf_mode_dec
    import bankrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank,
    output logic              has_sst
);
    always_comb begin
        case (mode)
            M_FIQ:   bank = B_FIQ;
            M_IRQ:   bank = B_IRQ;
            M_SVC:   bank = B_SVC;
            M_ABT:   bank = B_ABT;
            M_UND:   bank = B_UND;
            default: bank = B_USR;  // user, system and unlisted codes
        endcase
        has_sst = (bank != B_USR);
    end
endmodule

// File: rtl/bankrf_map.sv
module bankrf_map
    import bankrf_pkg::*;
(
    input  bank_e              bank,
    input  logic [IDX_W-1:0]   idx,
    output logic [PHYS_W-1:0]  phys
);
    localparam int HI_USR_BASE = NSHARED;
    localparam int HI_FIQ_BASE = NSHARED + NHIGH;
    localparam int PAIR_BASE   = NSHARED + 2 * NHIGH;

    int loc;

    always_comb begin
        if (idx < HI_IDX) begin
            loc = int'(idx);
        end else if (idx < SP_IDX) begin
            loc = ((bank == B_FIQ) ? HI_FIQ_BASE : HI_USR_BASE) + int'(idx) - int'(HI_IDX);
        end else if (idx != PC_IDX) begin
            loc = PAIR_BASE + int'(bank) * NPAIR + int'(idx) - int'(SP_IDX);
        end else begin
            loc = 0;  // program counter lives outside the array
        end
        phys = PHYS_W'(loc);
    end
endmodule

// File: rtl/bankrf_sst.sv
module bankrf_sst
    import bankrf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bank_e         bank,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [NSST-1:0][DW-1:0] word;
    } sst_t;

    sst_t sst_d, sst_q;

    always_comb begin
        sst_d = sst_q;
        if (wr_en && bank != B_USR) begin
            sst_d.word[int'(bank) - 1] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sst_q <= '0;
        else        sst_q <= sst_d;
    end

    assign rd_data = (bank == B_USR) ? '0 : sst_q.word[int'(bank) - 1];

    // R8: no stored word moves when the current bank owns none
    p_sst_user_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == B_USR) |=> $stable(sst_q));

    // R8: a write in an exception bank reads back next cycle if the bank holds
    p_sst_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank != B_USR) ##1 (bank == $past(bank)) |-> rd_data == $past(wr_data));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankrf_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] PC_RESET = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_wr_en,
    input  logic [MODE_W-1:0]    mode_wr_data,
    output logic [MODE_W-1:0]    cur_mode,
    input  logic [IDX_W-1:0]     rd_a_idx,
    output logic [DATA_W-1:0]    rd_a_data,
    input  logic [IDX_W-1:0]     rd_b_idx,
    output logic [DATA_W-1:0]    rd_b_data,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 sst_wr_en,
    input  logic [DATA_W-1:0]    sst_wr_data,
    output logic [DATA_W-1:0]    sst_rd_data,
    input  logic                 pc_wr_en,
    input  logic [DATA_W-1:0]    pc_wr_data,
    output logic [DATA_W-1:0]    pc_q
);
    localparam int NPORT = 3;  // read A, read B, write

    typedef struct packed {
        logic [NGPR-1:0][DATA_W-1:0] gpr;
        logic [DATA_W-1:0]           pc;
        logic [MODE_W-1:0]           mode;
    } rf_t;

    rf_t   rf_d, rf_q;
    bank_e bank;
    logic  has_sst;

    logic [IDX_W-1:0]  port_idx  [NPORT];
    logic [PHYS_W-1:0] port_phys [NPORT];

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign port_idx[2] = wr_idx;

    bankrf_mode_dec u_dec (
        .mode    (rf_q.mode),
        .bank    (bank),
        .has_sst (has_sst)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        bankrf_map u_map (
            .bank (bank),
            .idx  (port_idx[p]),
            .phys (port_phys[p])
        );
    end

    bankrf_sst #(.DW(DATA_W)) u_sst (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank    (bank),
        .wr_en   (sst_wr_en),
        .wr_data (sst_wr_data),
        .rd_data (sst_rd_data)
    );

    always_comb begin
        rf_d = rf_q;
        if (mode_wr_en) rf_d.mode = mode_wr_data;
        if (wr_en) begin
            if (wr_idx == PC_IDX) rf_d.pc = wr_data;
            else                  rf_d.gpr[port_phys[2]] = wr_data;
        end
        if (pc_wr_en) rf_d.pc = pc_wr_data;  // dedicated path has priority
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q.gpr  <= '0;
            rf_q.pc   <= PC_RESET;
            rf_q.mode <= M_SVC;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign cur_mode  = rf_q.mode;
    assign pc_q      = rf_q.pc;
    assign rd_a_data = (rd_a_idx == PC_IDX) ? rf_q.pc : rf_q.gpr[port_phys[0]];
    assign rd_b_data = (rd_b_idx == PC_IDX) ? rf_q.pc : rf_q.gpr[port_phys[1]];

    // R2: the mode register takes the loaded code
    p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_en |=> cur_mode == $past(mode_wr_data));

    // R9: dedicated program-counter write wins any collision
    p_pc_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_en |=> pc_q == $past(pc_wr_data));

    // R9: program counter holds without a write on either path
    p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr_en && !(wr_en && wr_idx == PC_IDX)) |=> $stable(pc_q));

    // R3: a register write lands in the mapped slot at the edge
    p_gpr_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != PC_IDX) |=> rf_q.gpr[$past(port_phys[2])] == $past(wr_data));

    // R8: saved-status port is silent without an owning bank
    p_sst_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !has_sst |-> sst_rd_data == '0);
endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                           SYS = 5'b11111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr_en = 1'b0;
    logic [4:0]  mode_wr_data = '0;
    logic [4:0]  cur_mode;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, sst_rd_data, pc_q;
    logic        wr_en = 1'b0, sst_wr_en = 1'b0, pc_wr_en = 1'b0;
    logic [31:0] wr_data = '0, sst_wr_data = '0, pc_wr_data = '0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    banked_regfile u_banked_regfile (
        .clk(clk), .rst_n(rst_n),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data), .cur_mode(cur_mode),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sst_wr_en(sst_wr_en), .sst_wr_data(sst_wr_data), .sst_rd_data(sst_rd_data),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .pc_q(pc_q)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // inputs change 1 ns after a rising edge; checks follow 1 ns later
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(logic [4:0] m);
        mode_wr_en = 1'b1; mode_wr_data = m;
        tick();
        mode_wr_en = 1'b0;
    endtask

    task automatic wr(logic [3:0] i, logic [31:0] d);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(string req, logic [3:0] i, logic [31:0] exp);
        rd_a_idx = i; rd_b_idx = i;
        #1;
        chk(req, rd_a_data, exp);
        chk(req, rd_b_data, exp);
    endtask

    task automatic t_reset();
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        chk("R1 mode", {27'd0, cur_mode}, {27'd0, SVC});
        chk("R1 pc", pc_q, 32'd0);
        chk("R1 sst", sst_rd_data, 32'd0);
        for (int i = 0; i < 16; i++) rd("R1 reg", 4'(i), 32'd0);
    endtask

    task automatic t_shared_low();
        set_mode(SVC);
        for (int i = 0; i < 8; i++) wr(4'(i), 32'hA000_0000 + 32'(i));
        set_mode(FIQ);
        for (int i = 0; i < 8; i++) rd("R4 fiq", 4'(i), 32'hA000_0000 + 32'(i));
        wr(4'd5, 32'h5555_0005);
        set_mode(ABT);
        rd("R4 abt", 4'd5, 32'h5555_0005);
        set_mode(USR);
        rd("R4 usr", 4'd0, 32'hA000_0000);
    endtask

    task automatic t_high_overlay();
        set_mode(USR);
        for (int i = 8; i < 13; i++) wr(4'(i), 32'hB000_0000 + 32'(i));
        set_mode(FIQ);
        for (int i = 8; i < 13; i++) rd("R5 fiq fresh", 4'(i), 32'd0);
        for (int i = 8; i < 13; i++) wr(4'(i), 32'hF000_0000 + 32'(i));
        set_mode(IRQ);
        for (int i = 8; i < 13; i++) rd("R5 irq", 4'(i), 32'hB000_0000 + 32'(i));
        set_mode(SYS);
        rd("R5 sys", 4'd12, 32'hB000_000C);
        set_mode(FIQ);
        rd("R5 fiq kept", 4'd8, 32'hF000_0008);
    endtask

    task automatic t_pair_banks();
        logic [4:0] ms [6] = '{USR, FIQ, IRQ, SVC, ABT, UND};
        for (int k = 0; k < 6; k++) begin
            set_mode(ms[k]);
            wr(4'd13, 32'h1300_0000 + 32'(k));
            wr(4'd14, 32'h1400_0000 + 32'(k));
        end
        for (int k = 5; k >= 0; k--) begin
            set_mode(ms[k]);
            rd("R6 sp", 4'd13, 32'h1300_0000 + 32'(k));
            rd("R6 lr", 4'd14, 32'h1400_0000 + 32'(k));
        end
        set_mode(SYS);
        rd("R6 sys sp", 4'd13, 32'h1300_0000);
        wr(4'd14, 32'h1400_00AA);
        set_mode(USR);
        rd("R6 usr lr shared", 4'd14, 32'h1400_00AA);
    endtask

    task automatic t_bad_mode();
        set_mode(5'b00000);
        chk("R7 code held", {27'd0, cur_mode}, 32'd0);
        rd("R7 sp", 4'd13, 32'h1300_0000);
        rd("R7 r8", 4'd8, 32'hB000_0008);
        chk("R7 sst", sst_rd_data, 32'd0);
        set_mode(5'b10110);
        rd("R7 lr", 4'd14, 32'h1400_00AA);
    endtask

    task automatic t_saved_status();
        logic [4:0] ms [5] = '{FIQ, IRQ, SVC, ABT, UND};
        for (int k = 0; k < 5; k++) begin
            set_mode(ms[k]);
            sst_wr_en = 1'b1; sst_wr_data = 32'h5C00_0000 + 32'(k);
            tick();
            sst_wr_en = 1'b0;
            chk("R8 write", sst_rd_data, 32'h5C00_0000 + 32'(k));
        end
        set_mode(USR);
        sst_wr_en = 1'b1; sst_wr_data = 32'hDEAD_BEEF;
        tick();
        sst_wr_en = 1'b0;
        chk("R8 usr zero", sst_rd_data, 32'd0);
        set_mode(SYS);
        sst_wr_en = 1'b1; sst_wr_data = 32'hFEED_F00D;
        tick();
        sst_wr_en = 1'b0;
        chk("R8 sys zero", sst_rd_data, 32'd0);
        for (int k = 0; k < 5; k++) begin
            set_mode(ms[k]);
            chk("R8 kept", sst_rd_data, 32'h5C00_0000 + 32'(k));
        end
    endtask

    task automatic t_pc();
        pc_wr_en = 1'b1; pc_wr_data = 32'h0000_1000;
        tick();
        pc_wr_en = 1'b0;
        chk("R9 pc write", pc_q, 32'h0000_1000);
        rd("R9 idx15", 4'd15, 32'h0000_1000);
        wr(4'd15, 32'h0000_2000);
        chk("R9 via port", pc_q, 32'h0000_2000);
        wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_3000;
        pc_wr_en = 1'b1; pc_wr_data = 32'h0000_4000;
        tick();
        wr_en = 1'b0; pc_wr_en = 1'b0;
        chk("R9 collision", pc_q, 32'h0000_4000);
        rd("R9 collision read", 4'd15, 32'h0000_4000);
        set_mode(FIQ);
        rd("R9 fiq pc", 4'd15, 32'h0000_4000);
    endtask

    task automatic t_same_cycle();
        set_mode(IRQ);
        rd_a_idx = 4'd3; rd_b_idx = 4'd3;
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h3333_CAFE;
        #1;
        chk("R3 old before edge", rd_a_data, 32'hA000_0003);
        tick();
        wr_en = 1'b0;
        chk("R3 new after edge", rd_a_data, 32'h3333_CAFE);
        chk("R3 port b", rd_b_data, 32'h3333_CAFE);
        mode_wr_en = 1'b1; mode_wr_data = UND;
        rd_a_idx = 4'd13;
        #1;
        chk("R2 old bank before edge", rd_a_data, 32'h1300_0002);
        tick();
        mode_wr_en = 1'b0;
        chk("R2 new bank", rd_a_data, 32'h1300_0005);
    endtask

    initial begin
        #1;
        t_reset();
        t_shared_low();
        t_high_overlay();
        t_pair_banks();
        t_bad_mode();
        t_saved_status();
        t_pc();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule